// File: doc/BRIEF.md
# Three-Wire Link Packet Receiver

This block is the host end of a three-wire, fully interlocked serial link on which the guest owns the CLK line, the host owns the ACK line and the guest drives DATA. When the guest pulls CLK low while the host is ready, the host answers by lowering ACK. The guest then either commits to a transfer, by holding DATA low when it raises CLK again, or drops the request. Once a transfer is committed, every change of CLK carries one data bit, and the host copies the new CLK level onto ACK to acknowledge it.

The first byte of a packet is a header. It carries a format-control bit that must be set and a payload length field. The receiver assembles the header and its payload bytes into a flat byte buffer. It then runs the closing exchange, which carries a parity bit followed by a stop bit. At the end it reports the result once, as a single-cycle done pulse with held status flags. It also says whether the packet is the greeting that a guest sends after it resets. The CLK and DATA inputs are expected to be synchronous to `clk` already.

Top module: `tw_rx_top`

## Requirements
- R1: After reset, link_ack_o is 1, and pkt_done_o, pkt_abort_o, all three error flags and hello_o are 0.
- R2: In the idle state, with link_clk_i low and rx_ready_i high, link_ack_o goes to 0 one clock later. While rx_ready_i is 0, link_ack_o stays at 1 even if CLK is low.
- R3: After the host has lowered ACK, a rise of CLK makes link_ack_o return to 1 one clock later. If DATA is 0 at that rise, the transfer is committed. If DATA is 1, pkt_abort_o pulses for one cycle and no done pulse follows.
- R4: In a committed transfer, each change of CLK samples one DATA bit, and one clock later link_ack_o equals the new CLK level. Bits fill each byte least significant bit first. Byte k (the header is k=0) appears on pkt_bytes_o[8k+7:8k].
- R5: If bit 3 of the header is 0, then one clock after the header's last bit pkt_done_o pulses with err_format_o=1, and the receiver returns to idle with link_ack_o at 1.
- R6: Header bits 2:0 give the payload byte count N (0 to 7), reported on pkt_len_o. The buffer holds 8 bytes, and bytes above index N read 0.
- R7: After the last data bit, the guest lowers CLK with parity on DATA, and link_ack_o goes to 0 one clock later. err_parity_o is 1 when that bit differs from the XOR of all received data bits. The handshake still completes.
- R8: At the next CLK rise, DATA is the stop bit. One clock later pkt_done_o pulses for exactly one cycle, link_ack_o is 1, and err_frame_o is 1 exactly when the stop bit was 0. Done and abort never pulse together.
- R9: With a done pulse, hello_o is 1 exactly when byte 0 equals 0x19, bits 7:4 of byte 1 equal 1, and neither a parity nor a framing error occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_ready_i | input | 1 | Host is willing to accept a packet |
| link_clk_i | input | 1 | Guest-driven CLK line level |
| link_data_i | input | 1 | Guest-driven DATA line level |
| link_ack_o | output | 1 | Host-driven ACK line level |
| pkt_done_o | output | 1 | One-cycle pulse: a packet has ended (good or bad) |
| pkt_abort_o | output | 1 | One-cycle pulse: the guest dropped its request |
| pkt_bytes_o | output | 64 | Header and payload bytes, byte k at bits 8k+7:8k |
| pkt_len_o | output | 3 | Payload byte count of the last packet |
| err_format_o | output | 1 | Header format-control bit was 0 |
| err_parity_o | output | 1 | Parity bit mismatch |
| err_frame_o | output | 1 | Stop bit was 0 |
| hello_o | output | 1 | Last packet was a clean greeting packet |

## Verification
A bit counter that slips by one shows up in the same packet. The closing exchange starts one CLK edge too early or too late, so ACK lowers on the wrong edge, the done pulse comes one bit period off, and the buffer shows shifted bytes. A stale length register or parity accumulator shows up at the done pulse of the affected packet, as a wrong pkt_len_o, an uncleared upper byte or a false err_parity_o. The sweep runs every payload length with several byte patterns so that each of these states is exercised. ACK is compared with CLK after every bit, so a handshake fault is seen within one bit.

// File: rtl/tw_rx_pkg.sv
package tw_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_BITS,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  localparam int BYTE_W = 8;

  // Format-control bit of a header byte must be set.
  function automatic logic hdr_format_ok(input logic [BYTE_W-1:0] hdr);
    return hdr[3];
  endfunction

  // Payload byte count carried in the low header bits.
  function automatic logic [2:0] hdr_payload(input logic [BYTE_W-1:0] hdr);
    return hdr[2:0];
  endfunction

  // Greeting packet: fixed header and id nibble in the next byte.
  function automatic logic is_greeting(input logic [BYTE_W-1:0] b0,
                                       input logic [BYTE_W-1:0] b1);
    return (b0 == 8'h19) && (b1[7:4] == 4'h1);
  endfunction

endpackage

// File: rtl/tw_rx_edge.sv
module tw_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic toggle_o,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= line_i;
  end

  assign toggle_o = line_i ^ prev_q;
  assign rise_o   = line_i & ~prev_q;
  assign fall_o   = ~line_i & prev_q;
endmodule

// File: rtl/tw_rx_assembler.sv
module tw_rx_assembler #(
  parameter int MAX_BYTES = 8,
  localparam int BW       = tw_rx_pkg::BYTE_W,
  localparam int TOTAL    = MAX_BYTES * BW,
  localparam int CNT_W    = $clog2(TOTAL + 1),
  localparam int IDX_W    = CNT_W - 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [TOTAL-1:0] bytes_o,
  output logic             byte_done_o,
  output logic [BW-1:0]    new_byte_o,
  output logic [IDX_W-1:0] byte_idx_o,
  output logic             parity_o
);
  logic [CNT_W-1:0] bit_cnt_q;
  logic [BW-1:0]    sr_q;

  assign new_byte_o  = {bit_i, sr_q[BW-1:1]};
  assign byte_done_o = shift_i && (bit_cnt_q[2:0] == 3'd7);
  assign byte_idx_o  = bit_cnt_q[CNT_W-1:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q <= '0;
      sr_q      <= '0;
      parity_o  <= 1'b0;
    end else if (clear_i) begin
      bit_cnt_q <= '0;
      sr_q      <= '0;
      parity_o  <= 1'b0;
    end else if (shift_i) begin
      bit_cnt_q <= bit_cnt_q + 1'b1;
      sr_q      <= new_byte_o;
      parity_o  <= parity_o ^ bit_i;
    end
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        bytes_o[g*BW +: BW] <= '0;
      else if (clear_i)                                  bytes_o[g*BW +: BW] <= '0;
      else if (byte_done_o && byte_idx_o == IDX_W'(g))   bytes_o[g*BW +: BW] <= new_byte_o;
    end
  end

  // Shifting never runs past the buffer.
  assert_no_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |-> (bit_cnt_q < CNT_W'(TOTAL)));
endmodule

// File: rtl/tw_rx_top.sv
module tw_rx_top #(
  parameter int MAX_BYTES = 8,
  localparam int BW       = tw_rx_pkg::BYTE_W,
  localparam int TOTAL    = MAX_BYTES * BW,
  localparam int LEN_W    = $clog2(MAX_BYTES),
  localparam int IDX_W    = $clog2(TOTAL + 1) - 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_ready_i,
  input  logic             link_clk_i,
  input  logic             link_data_i,
  output logic             link_ack_o,
  output logic             pkt_done_o,
  output logic             pkt_abort_o,
  output logic [TOTAL-1:0] pkt_bytes_o,
  output logic [LEN_W-1:0] pkt_len_o,
  output logic             err_format_o,
  output logic             err_parity_o,
  output logic             err_frame_o,
  output logic             hello_o
);
  import tw_rx_pkg::*;

  rx_state_e        state_q;
  logic [LEN_W-1:0] hdr_len_q;
  logic             par_bad_q;

  // Named internal events.
  logic             clk_tog_w, clk_rise_w, clk_fall_w;
  logic             start_w, shift_w;
  logic             byte_done_w, parity_w;
  logic [BW-1:0]    new_byte_w;
  logic [IDX_W-1:0] byte_idx_w;
  logic [LEN_W-1:0] payload_now_w;
  logic             fmt_bad_w, last_bit_w;

  tw_rx_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_i   (link_clk_i),
    .toggle_o (clk_tog_w),
    .rise_o   (clk_rise_w),
    .fall_o   (clk_fall_w)
  );

  assign start_w = (state_q == ST_IDLE) && !link_clk_i && rx_ready_i;
  assign shift_w = (state_q == ST_BITS) && clk_tog_w;

  tw_rx_assembler #(.MAX_BYTES(MAX_BYTES)) u_asm (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (start_w),
    .shift_i     (shift_w),
    .bit_i       (link_data_i),
    .bytes_o     (pkt_bytes_o),
    .byte_done_o (byte_done_w),
    .new_byte_o  (new_byte_w),
    .byte_idx_o  (byte_idx_w),
    .parity_o    (parity_w)
  );

  assign payload_now_w = (byte_idx_w == '0) ? LEN_W'(hdr_payload(new_byte_w)) : hdr_len_q;
  assign fmt_bad_w     = byte_done_w && (byte_idx_w == '0) && !hdr_format_ok(new_byte_w);
  assign last_bit_w    = byte_done_w && (byte_idx_w == IDX_W'(payload_now_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      link_ack_o   <= 1'b1;
      pkt_done_o   <= 1'b0;
      pkt_abort_o  <= 1'b0;
      hdr_len_q    <= '0;
      par_bad_q    <= 1'b0;
      pkt_len_o    <= '0;
      err_format_o <= 1'b0;
      err_parity_o <= 1'b0;
      err_frame_o  <= 1'b0;
      hello_o      <= 1'b0;
    end else begin
      pkt_done_o  <= 1'b0;
      pkt_abort_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_w) begin
            link_ack_o <= 1'b0;
            state_q    <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (clk_rise_w) begin
            link_ack_o <= 1'b1;
            if (!link_data_i) begin
              state_q <= ST_BITS;
            end else begin
              pkt_abort_o <= 1'b1;
              state_q     <= ST_IDLE;
            end
          end
        end
        ST_BITS: begin
          if (clk_tog_w) begin
            link_ack_o <= link_clk_i;
            if (byte_done_w && byte_idx_w == '0) hdr_len_q <= payload_now_w;
            if (fmt_bad_w) begin
              link_ack_o   <= 1'b1;
              pkt_done_o   <= 1'b1;
              err_format_o <= 1'b1;
              err_parity_o <= 1'b0;
              err_frame_o  <= 1'b0;
              hello_o      <= 1'b0;
              pkt_len_o    <= payload_now_w;
              state_q      <= ST_IDLE;
            end else if (last_bit_w) begin
              state_q <= ST_PAR;
            end
          end
        end
        ST_PAR: begin
          if (clk_fall_w) begin
            link_ack_o <= 1'b0;
            par_bad_q  <= (link_data_i != parity_w);
            state_q    <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (clk_rise_w) begin
            link_ack_o   <= 1'b1;
            pkt_done_o   <= 1'b1;
            err_format_o <= 1'b0;
            err_parity_o <= par_bad_q;
            err_frame_o  <= !link_data_i;
            hello_o      <= is_greeting(pkt_bytes_o[BW-1:0], pkt_bytes_o[2*BW-1:BW])
                            && !par_bad_q && link_data_i;
            pkt_len_o    <= hdr_len_q;
            state_q      <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // An abort is only reported when DATA was high at the commit sample.
  assert_abort_high_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_abort_o |-> $past(link_data_i));

  // Entering bit transfer requires DATA low at the commit sample.
  assert_commit_low_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BITS && $past(state_q) == ST_REQ) |-> !$past(link_data_i));

  // During data bits, ACK mirrors the CLK level seen at the edge.
  assert_ack_tracks_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_w && !fmt_bad_w) |=> (link_ack_o == $past(link_clk_i)));

  // Framing flag reflects the stop bit sampled at the done edge.
  assert_frame_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done_o && !err_format_o) |-> (err_frame_o == !$past(link_data_i)));

  // A packet ends in exactly one way.
  assert_single_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_done_o && pkt_abort_o));

  // A greeting is never flagged for a damaged packet.
  assert_hello_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done_o && hello_o) |-> (!err_parity_o && !err_frame_o && !err_format_o));
endmodule

// File: tb/tw_rx_top_bench.sv
`timescale 1ns/1ps
module tw_rx_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ready = 1'b1;
  logic        lclk = 1'b1;
  logic        ldata = 1'b1;
  logic        ack, done, abort_p, e_fmt, e_par, e_frm, hello;
  logic [63:0] bytes;
  logic [2:0]  plen;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tw_rx_top u_tw_rx_top (
    .clk(clk), .rst_n(rst_n), .rx_ready_i(ready),
    .link_clk_i(lclk), .link_data_i(ldata), .link_ack_o(ack),
    .pkt_done_o(done), .pkt_abort_o(abort_p), .pkt_bytes_o(bytes),
    .pkt_len_o(plen), .err_format_o(e_fmt), .err_parity_o(e_par),
    .err_frame_o(e_frm), .hello_o(hello)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      summary();
    end
  end

  // One data bit: toggle CLK, then ACK must follow (R4).
  task automatic step_bit(input logic b);
    @(negedge clk); ldata = b; lclk = ~lclk;
    @(negedge clk);
    chk(ack === lclk, "R4 ack follows clk", ack, lclk);
  endtask

  // Request phase; rts=1 commits, rts=0 aborts. wait_ready>0 holds ready low first.
  task automatic request(input bit rts, input int wait_ready);
    if (wait_ready > 0) ready = 1'b0;
    @(negedge clk); lclk = 1'b0;
    if (wait_ready > 0) begin
      repeat (wait_ready) @(negedge clk);
      chk(ack === 1'b1, "R2 ack held while not ready", ack, 1);
      ready = 1'b1;
    end
    @(negedge clk);
    chk(ack === 1'b0, "R2 ack lowered", ack, 0);
    ldata = rts ? 1'b0 : 1'b1;
    @(negedge clk); lclk = 1'b1;
    @(negedge clk);
    chk(ack === 1'b1, "R3 ack raised at commit", ack, 1);
    chk(abort_p === !rts, "R3 abort pulse", abort_p, !rts);
    chk(done === 1'b0, "R3 no done at request", done, 0);
    ldata = 1'b1;
  endtask

  task automatic run_packet(input logic [63:0] raw, input bit flip_par, input bit stop, input int wait_ready);
    int n;
    logic [63:0] exp;
    logic par;
    logic exp_hello;
    n = int'(raw[2:0]);
    exp = '0;
    for (int i = 0; i < 8 * (n + 1); i++) exp[i] = raw[i];
    par = 1'b0;
    for (int i = 0; i < 8 * (n + 1); i++) par = par ^ exp[i];
    exp_hello = (exp[7:0] == 8'h19) && (exp[15:12] == 4'h1) && !flip_par && stop;
    request(1, wait_ready);
    for (int i = 0; i < 8 * (n + 1); i++) step_bit(exp[i]);
    @(negedge clk); ldata = par ^ flip_par; lclk = 1'b0;
    @(negedge clk);
    chk(ack === 1'b0, "R7 ack lowered after parity", ack, 0);
    chk(done === 1'b0, "R7 no done before stop", done, 0);
    @(negedge clk); ldata = stop; lclk = 1'b1;
    @(negedge clk);
    chk(done === 1'b1, "R8 done pulse", done, 1);
    chk(ack === 1'b1, "R8 ack idle high", ack, 1);
    chk(e_par === flip_par, "R7 parity flag", e_par, flip_par);
    chk(e_frm === !stop, "R8 frame flag", e_frm, !stop);
    chk(e_fmt === 1'b0, "R5 no format flag", e_fmt, 0);
    chk(plen === 3'(n), "R6 payload length", plen, n);
    chk(bytes === exp, "R4 R6 buffer contents", bytes, exp);
    chk(hello === exp_hello, "R9 greeting match", hello, exp_hello);
    ldata = 1'b1;
    @(negedge clk);
    chk(done === 1'b0, "R8 done is one cycle", done, 0);
  endtask

  function automatic logic [63:0] make_pkt(input int seed, input int n);
    logic [63:0] p;
    p = '0;
    p[7:0] = {4'((seed * 5 + 3) % 16), 1'b1, 3'(n)};
    for (int k = 1; k < 8; k++) p[8*k +: 8] = 8'((k * 29 + seed * 71 + 13) % 256);
    return p;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ack === 1'b1, "R1 reset ack", ack, 1);
    chk({done, abort_p, e_fmt, e_par, e_frm, hello} === 6'b0, "R1 reset flags",
        {done, abort_p, e_fmt, e_par, e_frm, hello}, 0);

    // Sweep every payload length with several patterns.
    for (int s = 0; s < 4; s++)
      for (int n = 0; n < 8; n++)
        run_packet(make_pkt(s, n), 1'b0, 1'b1, 0);

    // Parity and framing faults, alone and together.
    run_packet(make_pkt(5, 3), 1'b1, 1'b1, 0);
    run_packet(make_pkt(6, 7), 1'b0, 1'b0, 0);
    run_packet(make_pkt(7, 0), 1'b1, 1'b0, 0);

    // Greeting packet, near misses, and greeting with a parity fault.
    run_packet(64'h0000_0000_0000_1219, 1'b0, 1'b1, 0);
    run_packet(64'h0000_0000_0000_2219, 1'b0, 1'b1, 0);
    run_packet(64'h0000_0000_0000_1218, 1'b0, 1'b1, 0);
    run_packet(64'h0000_0000_0000_1F19, 1'b1, 1'b1, 0);

    // Ready held low while CLK is low.
    run_packet(make_pkt(9, 2), 1'b0, 1'b1, 4);

    // Aborted request, then a normal packet.
    request(0, 0);
    @(negedge clk);
    chk(abort_p === 1'b0, "R3 abort is one cycle", abort_p, 0);
    chk(done === 1'b0, "R3 no done after abort", done, 0);
    run_packet(make_pkt(10, 4), 1'b0, 1'b1, 0);

    // Header with format bit cleared (0x52: bit3=0).
    request(1, 0);
    for (int i = 0; i < 8; i++) step_bit(8'h52 >> i);
    chk(done === 1'b1, "R5 done on bad header", done, 1);
    chk(e_fmt === 1'b1, "R5 format flag", e_fmt, 1);
    chk(ack === 1'b1, "R5 ack high after bad header", ack, 1);
    @(negedge clk);
    chk(done === 1'b0, "R5 done is one cycle", done, 0);
    run_packet(make_pkt(11, 5), 1'b0, 1'b1, 0);

    summary();
  end
endmodule